// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KB pages. It walks a two-level table that sits in ordinary memory. A request carries the linear address, a write flag, a user-mode flag and the frame number of the top-level (directory) table. The walker reads one directory word. From that word it finds the second-level table and reads one table word. It checks at each level that the entry is present and that the access is allowed. When the walk succeeds, it stores back the housekeeping bits that the entries need: the accessed mark and, for writes, the dirty mark.

The walker reaches memory through a single 32-bit word port. A request is held until the memory acknowledges it, and the memory may take any number of cycles. A walk ends in one of two ways. It can end with a one-cycle completion pulse that carries the physical address. It can also end with a one-cycle fault pulse that carries a two-bit cause. The walker serves one request at a time. A caller waits until `busy` falls and the completion or fault pulse has appeared before it issues the next request.

Top module: `pw_walker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done`, `fault`, `mem_req`, `fault_cause` and `phys_addr` are all zero.
- R2: The first memory access of a walk is a read at `{dir_frame, 12'h000} + 4*va[31:22]`. The low 12 bits of the request address play no part in it.
- R3: The second read is at `{pde[31:12], 12'h000} + 4*va[21:12]`, where `pde` is the directory word just read.
- R4: Entry bit 0 means present. If it is clear in the directory word, the walk faults with cause 2'b01 after one read, and the table word is never read. If it is clear in the table word, the walk faults with cause 2'b01 after two reads.
- R5: Entry bit 1 permits writes and bit 2 permits user access. A write to an entry whose bit 1 is 0, or a user access to an entry whose bit 2 is 0, at either level, faults with cause 2'b10. Presence is checked first.
- R6: On success, `done` pulses for one cycle and `phys_addr` = `{pte[31:12], va[11:0]}`. `done` and `fault` are never high together.
- R7: On success, bit 5 (accessed) is set in the directory word, and that word is written back only if bit 5 was clear. Every other bit of the word is kept.
- R8: On success, the table word is written with bit 5 set, and with bit 6 (dirty) set as well for writes. This write happens only if one of those bits was clear before. Every other bit of the word is kept.
- R9: A walk that faults writes nothing to memory.
- R10: Once `mem_req` is high, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high. Any latency of zero or more wait cycles is handled.
- R11: `busy` rises the cycle after a request is accepted. It stays high until the cycle in which `done` or `fault` is shown, where it is low. A request presented while a walk is in progress is ignored.
- R12: Write-backs happen only after both reads, and the directory word is written before the table word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_frame | input | 20 | Frame number of the directory table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 01 not present, 10 protection, valid with `fault` |
| phys_addr | output | 32 | Translated address, valid with `done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value being written back |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that the memory never acknowledges an access that was not requested. They also assume that the read data it returns with `mem_ack` is the word that sits at `mem_addr`. They further assume that a caller presents a new request only after the previous walk has reported completion or a fault. The bench memory model acknowledges only while `mem_req` is high. Its wait states rotate between zero and two cycles, and it returns the stored word at the requested address. The bench also drives a stray request in the middle of every walk. This exercises the idle-only acceptance rule without changing the walk under test.

// File: rtl/pw_pkg.sv
package pw_pkg;

  // Bit positions inside a directory or table entry.
  localparam int ENT_P   = 0;
  localparam int ENT_RW  = 1;
  localparam int ENT_US  = 2;
  localparam int ENT_ACC = 5;
  localparam int ENT_DRT = 6;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_DIR,
    S_CK_DIR,
    S_RD_TBL,
    S_CK_TBL,
    S_WB_DIR,
    S_WB_TBL,
    S_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_PROT   = 2'b10
  } fault_cause_e;

endpackage

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
(
  input  logic         present,
  input  logic         rw_ok,
  input  logic         us_ok,
  input  logic         is_write,
  input  logic         is_user,
  output logic         pass,
  output fault_cause_e cause
);

  function automatic logic allowed(input logic p, input logic rw, input logic us,
                                   input logic wr, input logic usr);
    return p && !(usr && !us) && !(wr && !rw);
  endfunction

  assign pass  = allowed(present, rw_ok, us_ok, is_write, is_user);
  assign cause = !present ? CAUSE_ABSENT : (pass ? CAUSE_NONE : CAUSE_PROT);

endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int IDX_W    = 10
) (
  input  walk_state_e                  state,
  input  logic [ADDR_W-OFFSET_W-1:0]   dir_frame,
  input  logic [ADDR_W-1:0]            vaddr,
  input  logic [ADDR_W-1:0]            pde,
  input  logic [ADDR_W-1:0]            pte,
  input  logic                         is_write,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [ADDR_W-1:0]            mem_wdata,
  output logic [ADDR_W-1:0]            pa_calc,
  output logic                         pde_wb_need,
  output logic                         pte_wb_need
);

  localparam int FRAME_W = ADDR_W - OFFSET_W;

  // Entry word address: frame base plus index times the 4-byte entry size.
  function automatic logic [ADDR_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                   input logic [IDX_W-1:0]   idx);
    return {frame, {OFFSET_W{1'b0}}} + ADDR_W'({idx, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] mark(input logic [ADDR_W-1:0] entry,
                                             input logic set_dirty);
    logic [ADDR_W-1:0] r;
    r = entry;
    r[ENT_ACC] = 1'b1;
    if (set_dirty) r[ENT_DRT] = 1'b1;
    return r;
  endfunction

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  assign dir_idx = vaddr[ADDR_W-1 -: IDX_W];
  assign tbl_idx = vaddr[OFFSET_W +: IDX_W];

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RD_DIR: mem_addr = entry_addr(dir_frame, dir_idx);
      S_WB_DIR: begin
        mem_addr  = entry_addr(dir_frame, dir_idx);
        mem_wdata = mark(pde, 1'b0);
      end
      S_RD_TBL: mem_addr = entry_addr(pde[ADDR_W-1:OFFSET_W], tbl_idx);
      S_WB_TBL: begin
        mem_addr  = entry_addr(pde[ADDR_W-1:OFFSET_W], tbl_idx);
        mem_wdata = mark(pte, is_write);
      end
      default: ;
    endcase
  end

  assign pa_calc     = {pte[ADDR_W-1:OFFSET_W], vaddr[OFFSET_W-1:0]};
  assign pde_wb_need = !pde[ENT_ACC];
  assign pte_wb_need = !pte[ENT_ACC] || (is_write && !pte[ENT_DRT]);

endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  // ADDR_W must equal OFFSET_W + 2*IDX_W, and OFFSET_W must equal IDX_W + 2.
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int IDX_W    = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic                       req_write,
  input  logic                       req_user,
  input  logic [ADDR_W-OFFSET_W-1:0] dir_frame,
  output logic                       busy,
  output logic                       done,
  output logic                       fault,
  output logic [1:0]                 fault_cause,
  output logic [ADDR_W-1:0]          phys_addr,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [ADDR_W-1:0]          mem_wdata,
  input  logic                       mem_ack,
  input  logic [ADDR_W-1:0]          mem_rdata
);

  localparam int FRAME_W = ADDR_W - OFFSET_W;
  localparam int LEVELS  = 2;

  walk_state_e          state_q;
  logic [ADDR_W-1:0]    vaddr_q;
  logic                 wr_q;
  logic                 user_q;
  logic [FRAME_W-1:0]   dframe_q;
  logic [ADDR_W-1:0]    pde_q;
  logic [ADDR_W-1:0]    pte_q;
  logic                 ok_q;
  fault_cause_e         cause_q;

  // Named events, also used by the checker.
  logic                 walk_accept;
  logic                 xfer;
  logic [ADDR_W-1:0]    pa_calc;
  logic                 pde_wb_need;
  logic                 pte_wb_need;

  logic [LEVELS-1:0]    lvl_present;
  logic [LEVELS-1:0]    lvl_rw;
  logic [LEVELS-1:0]    lvl_us;
  logic [LEVELS-1:0]    lvl_pass;
  fault_cause_e         lvl_cause [LEVELS];

  assign lvl_present = {pte_q[ENT_P],  pde_q[ENT_P]};
  assign lvl_rw      = {pte_q[ENT_RW], pde_q[ENT_RW]};
  assign lvl_us      = {pte_q[ENT_US], pde_q[ENT_US]};

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pw_entry_check u_check (
      .present  (lvl_present[g]),
      .rw_ok    (lvl_rw[g]),
      .us_ok    (lvl_us[g]),
      .is_write (wr_q),
      .is_user  (user_q),
      .pass     (lvl_pass[g]),
      .cause    (lvl_cause[g])
    );
  end

  pw_addr_gen #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .IDX_W    (IDX_W)
  ) u_addr (
    .state       (state_q),
    .dir_frame   (dframe_q),
    .vaddr       (vaddr_q),
    .pde         (pde_q),
    .pte         (pte_q),
    .is_write    (wr_q),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .pa_calc     (pa_calc),
    .pde_wb_need (pde_wb_need),
    .pte_wb_need (pte_wb_need)
  );

  assign walk_accept = (state_q == S_IDLE) && req_valid;
  assign mem_req     = (state_q == S_RD_DIR) || (state_q == S_RD_TBL) ||
                       (state_q == S_WB_DIR) || (state_q == S_WB_TBL);
  assign mem_we      = (state_q == S_WB_DIR) || (state_q == S_WB_TBL);
  assign xfer        = mem_req && mem_ack;

  assign busy        = (state_q != S_IDLE) && (state_q != S_RESP);
  assign done        = (state_q == S_RESP) && ok_q;
  assign fault       = (state_q == S_RESP) && !ok_q;
  assign fault_cause = fault ? cause_q : CAUSE_NONE;
  assign phys_addr   = done ? pa_calc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      vaddr_q  <= '0;
      wr_q     <= 1'b0;
      user_q   <= 1'b0;
      dframe_q <= '0;
      pde_q    <= '0;
      pte_q    <= '0;
      ok_q     <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (walk_accept) begin
          vaddr_q  <= req_vaddr;
          wr_q     <= req_write;
          user_q   <= req_user;
          dframe_q <= dir_frame;
          ok_q     <= 1'b0;
          cause_q  <= CAUSE_NONE;
          state_q  <= S_RD_DIR;
        end
        S_RD_DIR: if (xfer) begin
          pde_q   <= mem_rdata;
          state_q <= S_CK_DIR;
        end
        S_CK_DIR: begin
          if (!lvl_pass[0]) begin
            cause_q <= lvl_cause[0];
            state_q <= S_RESP;
          end else begin
            state_q <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (xfer) begin
          pte_q   <= mem_rdata;
          state_q <= S_CK_TBL;
        end
        S_CK_TBL: begin
          if (!lvl_pass[1]) begin
            cause_q <= lvl_cause[1];
            state_q <= S_RESP;
          end else begin
            ok_q <= 1'b1;
            if (pde_wb_need)      state_q <= S_WB_DIR;
            else if (pte_wb_need) state_q <= S_WB_TBL;
            else                  state_q <= S_RESP;
          end
        end
        S_WB_DIR: if (xfer) begin
          state_q <= pte_wb_need ? S_WB_TBL : S_RESP;
        end
        S_WB_TBL: if (xfer) begin
          state_q <= S_RESP;
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                walk_accept,
  input logic [OFFSET_W-1:0] acc_offset,
  input logic                xfer,
  input logic                busy,
  input logic                done,
  input logic                fault,
  input logic [1:0]          fault_cause,
  input logic [OFFSET_W-1:0] pa_offset,
  input logic                mem_req,
  input logic                mem_we,
  input logic                mem_ack,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [ADDR_W-1:0]   mem_wdata
);

  logic [OFFSET_W-1:0] off_q;
  logic                wrote_q;
  logic [1:0]          rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q    <= '0;
      wrote_q  <= 1'b0;
      rd_cnt_q <= '0;
    end else if (walk_accept) begin
      off_q    <= acc_offset;
      wrote_q  <= 1'b0;
      rd_cnt_q <= '0;
    end else if (xfer) begin
      if (mem_we) wrote_q <= 1'b1;
      else if (rd_cnt_q != 2'd3) rd_cnt_q <= rd_cnt_q + 2'd1;
    end
  end

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_cause == 2'b01 || fault_cause == 2'b10)); // R4
  AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault})); // R6
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pa_offset == off_q)); // R6
  AST_WB_ACC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]); // R7
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !wrote_q); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R10
  AST_BUSY_UNTIL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done || fault)); // R11
  AST_RESP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy); // R11
  AST_WB_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (rd_cnt_q == 2'd2)); // R12

endmodule

bind pw_walker pw_walker_chk #(
  .ADDR_W   (ADDR_W),
  .OFFSET_W (OFFSET_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .walk_accept (walk_accept),
  .acc_offset  (req_vaddr[OFFSET_W-1:0]),
  .xfer        (xfer),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .fault_cause (fault_cause),
  .pa_offset   (phys_addr[OFFSET_W-1:0]),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata)
);

// File: tb/pw_walker_tb.sv
module pw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] dir_frame = 20'h00001;
  logic        busy, done, fault;
  logic [1:0]  fault_cause;
  logic [31:0] phys_addr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  pw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_frame(dir_frame),
    .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
    .phys_addr(phys_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mem [0:4095];

  // Per-walk log kept by the memory model.
  int          lat = 0;
  int          n_rd, n_wr, hold_bad;
  logic [31:0] rd_a [2];
  logic [31:0] wr_a [2];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Memory model: acknowledges after lat wait cycles, logs every transfer.
  initial begin
    int wcnt = 0;
    logic in_req = 1'b0;
    logic [31:0] first_a = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem[mem_addr[13:2]];
        end else begin
          mem_ack = 1'b0;
          wcnt++;
        end
      end else begin
        mem_ack = 1'b0;
        wcnt = 0;
      end
      @(posedge clk);
      if (mem_req) begin
        if (!in_req) begin
          in_req  = 1'b1;
          first_a = mem_addr;
        end
        if (mem_ack) begin
          if (mem_addr !== first_a) hold_bad++;
          in_req = 1'b0;
          wcnt = 0;
          if (mem_we) begin
            if (n_wr < 2) wr_a[n_wr] = mem_addr;
            n_wr++;
            mem[mem_addr[13:2]] = mem_wdata;
          end else begin
            if (n_rd < 2) rd_a[n_rd] = mem_addr;
            n_rd++;
          end
        end
      end else begin
        in_req = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 0);
    chk("R1 resp in reset", {28'b0, done, fault, fault_cause}, 0);
    chk("R1 mem_req in reset", {31'b0, mem_req}, 0);
    chk("R1 phys_addr in reset", phys_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'b0, busy, mem_req, done | fault}, 0);

    for (int k = 0; k < 2048; k++) begin
      logic [3:0]  pf = 4'(k);
      logic [4:0]  tf = 5'(k >> 4);
      logic        wr = k[9];
      logic        us = k[10];
      logic [9:0]  d  = 10'((k * 7) % 1024);
      logic [9:0]  t  = 10'((k * 13 + 3) % 1024);
      logic [11:0] off = 12'((k * 97) % 4096);
      logic [19:0] frame = 20'(k * 37 + 5);
      logic [31:0] va = {d, t, off};
      logic [31:0] pde_a = 32'h1000 + {20'b0, d, 2'b00};
      logic [31:0] pte_a = 32'h2000 + {20'b0, t, 2'b00};
      logic [31:0] pde = 32'h0000_2100 | {26'b0, pf[3], 2'b00, pf[2:0]};
      logic [31:0] pte = {frame, 12'h100} | {25'b0, tf[4:3], 2'b00, tf[2:0]};
      logic        dir_ok, tbl_ok, ok, pde_need, pte_need;
      logic [1:0]  ecause;
      int          exp_rd, exp_wr;
      logic [31:0] exp_pde, exp_pte;
      logic        busy_bad = 1'b0;
      logic        got_resp = 1'b0;
      logic        r_done, r_fault, r_busy;
      logic [1:0]  r_cause;
      logic [31:0] r_pa;
      string       tag;

      // Expected outcome from the entry encodings.
      dir_ok = pde[0] && !(us && !pde[2]) && !(wr && !pde[1]);
      tbl_ok = pte[0] && !(us && !pte[2]) && !(wr && !pte[1]);
      ok = dir_ok && tbl_ok;
      if (!pde[0])      begin ecause = 2'b01; exp_rd = 1; end
      else if (!dir_ok) begin ecause = 2'b10; exp_rd = 1; end
      else if (!pte[0]) begin ecause = 2'b01; exp_rd = 2; end
      else if (!tbl_ok) begin ecause = 2'b10; exp_rd = 2; end
      else              begin ecause = 2'b00; exp_rd = 2; end
      pde_need = ok && !pde[5];
      pte_need = ok && (!pte[5] || (wr && !pte[6]));
      exp_wr  = int'(pde_need) + int'(pte_need);
      exp_pde = pde_need ? (pde | 32'h20) : pde;
      exp_pte = pte_need ? (pte | 32'h20 | (wr ? 32'h40 : 32'h0)) : pte;

      mem[pde_a[13:2]] = pde;
      mem[pte_a[13:2]] = pte;
      lat = k % 3;
      n_rd = 0; n_wr = 0; hold_bad = 0;
      rd_a[0] = '0; rd_a[1] = '0; wr_a[0] = '0; wr_a[1] = '0;

      @(negedge clk);
      req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
      @(negedge clk);
      // Stray request during the walk (R11): must be ignored.
      req_vaddr = ~va; req_write = ~wr; req_user = ~us;
      if (!busy) busy_bad = 1'b1;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        req_valid = 1'b0;
        if (done || fault) begin
          got_resp = 1'b1;
          break;
        end
        if (!busy) busy_bad = 1'b1;
      end
      r_done = done; r_fault = fault; r_cause = fault_cause;
      r_pa = phys_addr; r_busy = busy;
      chk("R11 response seen", {31'b0, got_resp}, 1);
      chk("R11 busy during walk", {30'b0, busy_bad, r_busy}, 0);
      tag = (ecause == 2'b01) ? "R4 outcome" : (ecause == 2'b10) ? "R5 outcome" : "R6 outcome";
      chk(tag, {28'b0, r_done, r_fault, r_cause}, {28'b0, ok, !ok, ecause});
      if (ok) chk("R6 phys_addr", r_pa, {frame, off});
      chk("R2 directory read address", rd_a[0], pde_a);
      chk(pde[0] ? "R3 read count" : "R4 read count", 32'(n_rd), 32'(exp_rd));
      if (exp_rd == 2) chk("R3 table read address", rd_a[1], pte_a);
      chk(ok ? "R7 write count" : "R9 write count", 32'(n_wr), 32'(exp_wr));
      chk("R7 directory word", mem[pde_a[13:2]], exp_pde);
      chk("R8 table word", mem[pte_a[13:2]], exp_pte);
      if (exp_wr == 2) chk("R12 write order", wr_a[0], pde_a);
      chk("R10 request held", 32'(hold_bad), 0);
      @(negedge clk);
      chk("R11 idle after response", {30'b0, busy, mem_req}, 0);
    end
    finish_run();
  end

endmodule